// File: doc/BRIEF.md
# Floating-point to integer converter

This block turns one IEEE-754 operand into an integer, always rounding toward zero. A format input says whether the operand is single or double precision. A 2-bit destination select picks one of four integer types: signed or unsigned, 32 or 64 bits. Some inputs have no exact integer answer: NaN, infinities, values outside the destination's range, and negative values sent to an unsigned type. For these the block drives a fixed saturation value and raises an invalid flag. It decides this from the exponent and mantissa fields before any conversion takes place, so it never depends on a trap mechanism.

The caller presents an operand with a one-cycle `inValid` strobe. Exactly one clock later the registered result appears, together with an `outValid` pulse and the invalid and inexact flags. The caller ORs those flags into its own accrued-flags register, so set bits are never cleared there. The result and flags keep their values until the next accepted operand.

Top module: `fp2int_conv`

## Requirements
- R1: An operand accepted with `inValid` high produces `outValid` high exactly one clock later. `outValid` is low in any cycle that follows a cycle without `inValid`, and in that cycle `result` and both flags keep their previous values.
- R2: `destSel` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. In-range values are truncated toward zero. Signed 32-bit results are sign-extended to 64 bits. Unsigned 32-bit results are zero-extended.
- R3: `flagInexact` is high exactly when nonzero fraction bits were discarded and `flagInvalid` is low. It is never high together with `flagInvalid`.
- R4: A NaN to a signed destination gives the most positive value of that width (0x000000007FFFFFFF or 0x7FFFFFFFFFFFFFFF) and raises invalid.
- R5: A NaN to an unsigned destination gives all 64 result bits set and raises invalid.
- R6: For a signed destination, an input whose truncated value exceeds the maximum gives that maximum and raises invalid. This includes +infinity, and a single-precision input of 2^31 or more to signed 32-bit.
- R7: For a signed destination, an input whose truncated value is below the minimum gives the most negative value, sign-extended to 64 bits, and raises invalid. This includes -infinity. The value exactly -2^31 (or -2^63) converts without a flag.
- R8: For an unsigned destination, a negative input whose truncated value is -1 or lower gives 0 and raises invalid. This includes -infinity. A negative input with magnitude below 1 gives 0 with only inexact raised.
- R9: For an unsigned destination, an input whose truncated value exceeds the maximum gives all 64 bits set and raises invalid. This holds for the 32-bit unsigned type too.
- R10: +0 and -0 give 0 with no flags in every mode. A subnormal gives 0 with inexact only.
- R11: With `isDouble` low, only `operand[31:0]` is used and `operand[63:32]` has no effect.
- R12: During reset, `outValid`, `result` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| isDouble | input | 1 | 1 = double precision, 0 = single in bits 31:0 |
| destSel | input | 2 | Destination integer type |
| operand | input | 64 | Floating-point operand bits |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 64 | Integer result |
| flagInvalid | output | 1 | Invalid-operation flag for this result |
| flagInexact | output | 1 | Inexact flag for this result |

## Verification
The converter has one register stage, so a wrong classification shows at the ports in the very next cycle after the operand is accepted. Examples are a NaN treated as infinity, an off-by-one range bound, or a wrong sign path. Each one shows up as a wrong saturation constant or a wrong flag pair. The bench walks every operand through all four destinations. It places operands right on each range boundary: ±2^31, ±2^63, 2^32 and 2^64, and just inside and outside them. An error in the shift or the boundary compare therefore appears within one clock on the single operand that crosses it. Idle cycles between operands expose any result that changes without `inValid`.

// File: rtl/fpcvt_pkg.sv
`timescale 1ns/1ps
package fpcvt_pkg;
  localparam int RES_W    = 64;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_BIAS  = (1 << (DP_EXP_W - 1)) - 1;
  localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
  localparam int UEXP_W   = 13;
  localparam int SIG_W    = DP_MAN_W + 1;
  localparam int WIDE_W   = 2 * RES_W;
  localparam int SH_BASE  = RES_W - DP_MAN_W;

  typedef enum logic [1:0] {
    DEST_S32 = 2'd0,
    DEST_U32 = 2'd1,
    DEST_S64 = 2'd2,
    DEST_U64 = 2'd3
  } destE;

  typedef struct packed {
    logic load;
  } strobeT;
endpackage

// File: rtl/fpcvt_ctrl.sv
`timescale 1ns/1ps
module fpcvt_ctrl
  import fpcvt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output strobeT strb,
  output logic   outValid
);
  always_comb strb.load = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/fpcvt_dp.sv
`timescale 1ns/1ps
module fpcvt_dp
  import fpcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic             isDouble,
  input  logic [1:0]       destSel,
  input  logic [RES_W-1:0] operand,
  output logic [RES_W-1:0] result,
  output logic             flagInvalid,
  output logic             flagInexact
);
  localparam logic [RES_W-1:0] ALL_ONES = '1;
  localparam logic [RES_W-1:0] S32_MAX  = 64'h0000_0000_7FFF_FFFF;
  localparam logic [RES_W-1:0] S32_MIN  = 64'hFFFF_FFFF_8000_0000;
  localparam logic [RES_W-1:0] S64_MAX  = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [RES_W-1:0] S64_MIN  = 64'h8000_0000_0000_0000;
  localparam logic [RES_W-1:0] POW31    = 64'h0000_0000_8000_0000;

  logic                     signBit, expAllOnes, expZero;
  logic [DP_MAN_W-1:0]      mantBits;
  logic signed [UEXP_W-1:0] expUnb;
  logic                     isNan, isInf, tooBig;
  logic [6:0]               shAmt;
  logic [WIDE_W-1:0]        wide;
  logic [RES_W-1:0]         intMag, negMag, resNext;
  logic                     fracNz, invNext, inxNext;

  // field unpack, single mantissa aligned to the double position
  always_comb begin
    if (isDouble) begin
      signBit    = operand[63];
      expAllOnes = &operand[62:52];
      expZero    = ~|operand[62:52];
      mantBits   = operand[51:0];
      expUnb     = $signed({2'b00, operand[62:52]}) - 13'sd1023;
    end else begin
      signBit    = operand[31];
      expAllOnes = &operand[30:23];
      expZero    = ~|operand[30:23];
      mantBits   = {operand[22:0], 29'd0};
      expUnb     = $signed({5'd0, operand[30:23]}) - 13'sd127;
    end
  end

  assign isNan  = expAllOnes && (|mantBits);
  assign isInf  = expAllOnes && !(|mantBits);
  assign tooBig = isInf || (!expZero && (expUnb >= 13'sd64));

  // integer magnitude and discarded-fraction detect
  always_comb begin
    shAmt = expUnb[6:0] + 7'(SH_BASE);
    wide  = {75'd0, 1'b1, mantBits} << shAmt;
    if (expZero) begin
      intMag = '0;
      fracNz = |mantBits;
    end else if (expUnb < 13'sd0) begin
      intMag = '0;
      fracNz = 1'b1;
    end else begin
      intMag = wide[WIDE_W-1:RES_W];
      fracNz = |wide[RES_W-1:0];
    end
    negMag = ~intMag + 64'd1;
  end

  // ordered checks: NaN, then range per destination, then normal result
  always_comb begin
    invNext = 1'b1;
    resNext = '0;
    unique case (destE'(destSel))
      DEST_S32: begin
        if (isNan)                                      resNext = S32_MAX;
        else if (!signBit && (tooBig || intMag >= POW31)) resNext = S32_MAX;
        else if (signBit && (tooBig || intMag > POW31))   resNext = S32_MIN;
        else begin
          invNext = 1'b0;
          resNext = signBit ? negMag : intMag;
        end
      end
      DEST_U32: begin
        if (isNan)                                              resNext = ALL_ONES;
        else if (signBit && (tooBig || intMag != '0))           resNext = '0;
        else if (!signBit && (tooBig || intMag[63:32] != '0))   resNext = ALL_ONES;
        else begin
          invNext = 1'b0;
          resNext = signBit ? '0 : intMag;
        end
      end
      DEST_S64: begin
        if (isNan)                                        resNext = S64_MAX;
        else if (!signBit && (tooBig || intMag[63]))      resNext = S64_MAX;
        else if (signBit && (tooBig || intMag > S64_MIN)) resNext = S64_MIN;
        else begin
          invNext = 1'b0;
          resNext = signBit ? negMag : intMag;
        end
      end
      default: begin
        if (isNan)                                    resNext = ALL_ONES;
        else if (signBit && (tooBig || intMag != '0)) resNext = '0;
        else if (!signBit && tooBig)                  resNext = ALL_ONES;
        else begin
          invNext = 1'b0;
          resNext = signBit ? '0 : intMag;
        end
      end
    endcase
    inxNext = fracNz && !invNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      flagInvalid <= 1'b0;
      flagInexact <= 1'b0;
    end else if (strb.load) begin
      result      <= resNext;
      flagInvalid <= invNext;
      flagInexact <= inxNext;
    end
  end

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> !flagInexact);
  a_r4_nan_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && isNan) |=> flagInvalid);
  a_r10_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && expZero && mantBits == '0) |=>
      (result == '0 && !flagInvalid && !flagInexact));
endmodule

// File: rtl/fp2int_conv.sv
`timescale 1ns/1ps
module fp2int_conv
  import fpcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isDouble,
  input  logic [1:0]  destSel,
  input  logic [63:0] operand,
  output logic        outValid,
  output logic [63:0] result,
  output logic        flagInvalid,
  output logic        flagInexact
);
  strobeT strb;

  fpcvt_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  fpcvt_dp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .isDouble    (isDouble),
    .destSel     (destSel),
    .operand     (operand),
    .result      (result),
    .flagInvalid (flagInvalid),
    .flagInexact (flagInexact)
  );

  a_r2_s32_sext: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(destSel) == 2'd0) |-> (result[63:32] == {32{result[31]}}));
  a_r2_u32_zext: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(destSel) == 2'd1 && !flagInvalid) |-> (result[63:32] == 32'd0));
  a_r1_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(flagInvalid) && $stable(flagInexact)));
endmodule

// File: tb/test_fp2int_conv.sv
`timescale 1ns/1ps
module test_fp2int_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        isDouble = 1'b0;
  logic [1:0]  destSel = 2'd0;
  logic [63:0] operand = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flagInvalid, flagInexact;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp2int_conv i_fp2int_conv (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
    .destSel(destSel), .operand(operand), .outValid(outValid),
    .result(result), .flagInvalid(flagInvalid), .flagInexact(flagInexact)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        inv;
    logic        inx;
  } expT;

  // behavioural reference: value classified by bounds, truncation by shifting
  function automatic expT model(logic [63:0] op, bit dbl, int dest);
    expT r;
    bit s, nan, inf, sub, big, fr;
    int ef, e;
    logic [63:0] mf, sig, ip;
    if (dbl) begin
      s = op[63]; ef = int'(op[62:52]); mf = {12'd0, op[51:0]};
      nan = (ef == 2047) && (mf != 0); inf = (ef == 2047) && (mf == 0);
      e = ef - 1023;
    end else begin
      s = op[31]; ef = int'(op[30:23]); mf = {12'd0, op[22:0], 29'd0};
      nan = (ef == 255) && (mf != 0); inf = (ef == 255) && (mf == 0);
      e = ef - 127;
    end
    sub = (ef == 0);
    big = 0; ip = 0; fr = 0;
    if (sub) fr = (mf != 0);
    else if (inf || e >= 64) big = 1;
    else begin
      sig = mf | (64'd1 << 52);
      if (e >= 52) ip = sig << (e - 52);
      else if (e >= 0) begin
        ip = sig >> (52 - e);
        fr = (sig & ((64'd1 << (52 - e)) - 64'd1)) != 0;
      end else fr = 1;
    end
    r.inv = 1;
    case (dest)
      0: begin
        if (nan) r.res = 64'h7FFFFFFF;
        else if (!s && (big || ip > 64'h7FFFFFFF)) r.res = 64'h7FFFFFFF;
        else if (s && (big || ip > 64'h80000000)) r.res = 64'hFFFFFFFF80000000;
        else begin r.inv = 0; r.res = s ? (64'd0 - ip) : ip; end
      end
      1: begin
        if (nan) r.res = '1;
        else if (s && (big || ip >= 1)) r.res = 0;
        else if (!s && (big || ip > 64'hFFFFFFFF)) r.res = '1;
        else begin r.inv = 0; r.res = s ? 64'd0 : ip; end
      end
      2: begin
        if (nan) r.res = 64'h7FFFFFFFFFFFFFFF;
        else if (!s && (big || ip > 64'h7FFFFFFFFFFFFFFF)) r.res = 64'h7FFFFFFFFFFFFFFF;
        else if (s && (big || ip > 64'h8000000000000000)) r.res = 64'h8000000000000000;
        else begin r.inv = 0; r.res = s ? (64'd0 - ip) : ip; end
      end
      default: begin
        if (nan) r.res = '1;
        else if (s && (big || ip >= 1)) r.res = 0;
        else if (!s && big) r.res = '1;
        else begin r.inv = 0; r.res = s ? 64'd0 : ip; end
      end
    endcase
    r.inx = fr && !r.inv;
    return r;
  endfunction

  expT prevExp = '0;

  task automatic step(input logic [63:0] op, input bit dbl, input int dest,
                      input bit vld, input string tag);
    expT ex;
    @(negedge clk);
    operand = op; isDouble = dbl; destSel = 2'(dest); inValid = vld;
    ex = vld ? model(op, dbl, dest) : prevExp;
    @(posedge clk);
    #1;
    nRun++;
    if (outValid !== vld || result !== ex.res || flagInvalid !== ex.inx ^ ex.inx ^ ex.inv
        || flagInexact !== ex.inx) begin
      nFail++;
      $display("FAIL %s op=%h dbl=%0d dest=%0d: got v=%0d res=%h inv=%0d inx=%0d exp v=%0d res=%h inv=%0d inx=%0d",
               tag, op, dbl, dest, outValid, result, flagInvalid, flagInexact,
               vld, ex.res, ex.inv, ex.inx);
    end
    if (vld) prevExp = ex;
  endtask

  task automatic allDest(input logic [63:0] op, input bit dbl, input string tag);
    for (int d = 0; d < 4; d++) step(op, dbl, d, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nRun++;
    if (outValid !== 1'b0 || result !== '0 || flagInvalid !== 1'b0 || flagInexact !== 1'b0) begin
      nFail++;
      $display("FAIL R12 reset: got v=%0d res=%h inv=%0d inx=%0d exp 0 0 0 0",
               outValid, result, flagInvalid, flagInexact);
    end
    rstN = 1'b1;
    // R2 truncation and extension, R3 inexact
    allDest(64'h3F800000, 0, "R2 one");
    allDest(64'h40200000, 0, "R3 2.5");
    allDest(64'hC0200000, 0, "R3 -2.5");
    allDest(64'h3FF8000000000000, 1, "R3 1.5d");
    allDest(64'hC01F000000000000, 1, "R2 -7.75d");
    allDest(64'h4F32D05E, 0, "R9 3e9");
    // R4 R5 NaN
    allDest(64'h7FC00000, 0, "R4 R5 nan s");
    allDest(64'hFFF8000000000001, 1, "R4 R5 nan d");
    allDest(64'h7F800001, 0, "R4 R5 snan s");
    // R6 R7 R8 R9 range boundaries and infinities
    allDest(64'h4F000000, 0, "R6 2^31");
    allDest(64'hCF000000, 0, "R7 -2^31");
    allDest(64'h4F800000, 0, "R9 2^32");
    allDest(64'h7F800000, 0, "R6 R9 +inf");
    allDest(64'hFF800000, 0, "R7 R8 -inf");
    allDest(64'h43E0000000000000, 1, "R6 2^63d");
    allDest(64'hC3E0000000000000, 1, "R7 -2^63d");
    allDest(64'hC3E0000000000001, 1, "R7 below -2^63d");
    allDest(64'h43F0000000000000, 1, "R9 2^64d");
    allDest(64'h43EFFFFFFFFFFFFF, 1, "R6 below 2^63d");
    allDest(64'hC1E0000000100000, 1, "R7 -2^31-0.5d");
    allDest(64'hC1E0000000200000, 1, "R7 -2^31-1d");
    allDest(64'h41EFFFFFFFE00000, 1, "R6 2^32-1d");
    allDest(64'hBF000000, 0, "R8 -0.5");
    allDest(64'hBF800000, 0, "R8 -1");
    // R10 zeros and subnormals
    allDest(64'h00000000, 0, "R10 +0");
    allDest(64'h80000000, 0, "R10 -0");
    allDest(64'h8000000000000000, 1, "R10 -0d");
    allDest(64'h00000001, 0, "R10 sub");
    allDest(64'h800FFFFFFFFFFFFF, 1, "R10 subd");
    // R11 upper bits ignored for single precision
    allDest(64'hDEADBEEF_40200000, 0, "R11 junk upper");
    allDest(64'h7FF80000_3F800000, 0, "R11 nan upper");
    // R1 idle cycles hold outputs
    step(64'h4F000000, 0, 1, 1'b1, "R1 load");
    step(64'h7FC00000, 0, 0, 1'b0, "R1 idle");
    step(64'hFF800000, 1, 3, 1'b0, "R1 idle2");
    step(64'h40200000, 0, 2, 1'b1, "R1 reload");
    step(64'h0, 0, 0, 1'b0, "R1 idle3");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule